// File: doc/BRIEF.md
# HyperBus Write Transaction Sequencer

This block carries out a single write request on a HyperBus-style double-data-rate memory link. A requester hands over a starting byte address and a byte count. The block then pulls the data bytes one at a time from a stream, and each byte carries its own write-enable. On the memory side it drives chip select, a single-ended bus clock and an 8-bit data bus. It also owns the output half of the read/write data strobe (RWDS), which serves as a byte mask during write data.

Each bus transaction moves through a fixed order: select, a 48-bit command/address word, a latency wait, the data, and deselect. The latency wait is one or two periods long. The memory chooses between them by the level it drives on RWDS while the command/address word goes out. The block caps how long chip select may stay low. Before the data of each bus transaction starts, it works out how many bytes still fit. A long request is therefore cut into several bus transactions. Each one restarts at the first byte not yet written and carries a freshly built command/address word.

The bus clock changes once per core clock cycle while it runs, so one bus edge lasts one core cycle. Data and mask are presented in the same cycle as the clock transition they belong to. The board-level phase shift that centres them on the edge sits outside this block.

Top module: `hb_write_seq`

## Requirements
- R1: After a synchronous active-low reset, `hb_cs_n` is 1, `hb_ck` is 0, `hb_dq_oe`, `hb_rwds_oe` and `done` are 0, and `req_ready` is 1.
- R2: Each bus transaction first sends six command/address bytes on six consecutive bus clock edges, most significant byte first. In that 48-bit word, bit 47 = 0 (write), bit 46 = 0 (memory space), bit 45 = 1 (linear burst), bits 44..16 hold word-address bits 31..3, bits 15..3 are 0 and bits 2..0 hold word-address bits 2..0. The word address is the byte address divided by two.
- R3: RWDS is sampled during the last command/address byte. If it is 1, the wait lasts 2 × `lat_clocks` clocks (4 × `lat_clocks` edges); otherwise it lasts `lat_clocks` clocks (2 × `lat_clocks` edges). `lat_clocks` lies between 3 and 12.
- R4: The block does not drive RWDS during the command/address edges or the latency edges. The only exception is the final latency clock (its two edges), where it drives RWDS low as a preamble.
- R5: In the data phase each bus edge carries one byte, starting at the even byte of the first word. RWDS is driven on every data edge and RWDS = 1 means "do not write". Bytes with `wr_be` = 0 are masked. A padding byte before an odd start address and a padding byte after an odd end address are also masked. The data-edge count is even and non-zero, and every requested byte is taken from the stream exactly once.
- R6: The bus clock is low whenever chip select is high. Chip select only changes while the bus clock is low, both before and after the change.
- R7: Chip select never stays low for more than `MAX_CSL` core cycles. A request that does not fit is split, and each later bus transaction starts at the first byte address not yet written.
- R8: Between two bus transactions, chip select stays high for at least `CSH_MIN` core cycles.
- R9: `req_ready` is 1 only while idle, and requests arriving while busy have no effect. A request with `req_len` = 0 is not accepted and causes no bus activity. `done` is a one-cycle pulse issued after chip select has returned high following the last bus transaction.
- R10: Each bus transaction uses E data edges, where E is the largest even number with 8 + L + E ≤ `MAX_CSL` and L is the latency edge count of R3. It carries min(remaining bytes, E − (1 if its start address is odd)) bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Write request present |
| req_addr | input | AW | Starting byte address |
| req_len | input | LW | Number of bytes to write |
| req_ready | output | 1 | Block idle, request taken on this cycle if valid |
| lat_clocks | input | 4 | Latency clock count, 3 to 12 |
| wr_data | input | 8 | Next data byte of the stream |
| wr_be | input | 1 | Enable for `wr_data`; 0 masks the byte |
| wr_ready | output | 1 | Stream byte consumed on this cycle |
| done | output | 1 | One-cycle completion pulse |
| hb_cs_n | output | 1 | Chip select, active low |
| hb_ck | output | 1 | Bus clock, idles low |
| hb_dq_o | output | 8 | Data bus output value |
| hb_dq_oe | output | 1 | Data bus output enable |
| hb_rwds_i | input | 1 | RWDS level seen at the pin |
| hb_rwds_o | output | 1 | RWDS output value (write mask) |
| hb_rwds_oe | output | 1 | RWDS output enable |

## Verification
The hardest situation to create from the ports is a split whose pieces get different latencies, because segment sizing then depends on a level the memory drives only during the command/address phase. The bench's memory model flips its RWDS answer after each deselect. A request long enough to split is combined with a double latency that leaves only a small data window. The next segment then sizes itself from a single latency and must restart at an odd or even address decided by the first cut. Odd start and end addresses and sparse byte enables are also mixed in, so that padding masks and enable masks fall on both edges of a word.

// File: rtl/hbw_pkg.sv
// Shared types and helpers for the HyperBus write sequencer.
// Assumes word addresses fit in 32 bits.
package hbw_pkg;
    typedef enum logic [2:0] {ST_IDLE, ST_SEL, ST_CA, ST_LAT, ST_DATA, ST_GAP} seq_state_e;

    // Number of command/address bytes per transaction.
    localparam int CA_BYTES = 6;
    // Core cycles of chip-select-low time outside latency and data: select + CA + close.
    localparam int CS_OVERHEAD = CA_BYTES + 2;

    // Builds the 48-bit write command/address word for a linear burst into memory space.
    function automatic logic [47:0] build_ca(input logic [31:0] wa);
        build_ca = {3'b001, wa[31:3], 13'd0, wa[2:0]};
    endfunction
endpackage

// File: rtl/hbw_ca_byte.sv
// Selects one byte of the command/address word, byte 0 being the most significant.
// Assumes idx stays below 6; larger values give zero.
module hbw_ca_byte (
    input  logic [47:0] ca,
    input  logic [2:0]  idx,
    output logic [7:0]  byte_o
);
    // Byte multiplexer over the six command/address bytes.
    always_comb begin
        byte_o = 8'h00;
        for (int i = 0; i < 6; i++) begin
            if (idx == 3'(i)) byte_o = ca[47 - 8*i -: 8];
        end
    end
endmodule

// File: rtl/hbw_seg_plan.sv
// Sizes one bus transaction: how many bytes and data edges fit in the
// chip-select-low budget once the latency edge count is known.
// Assumes MAX_CSL leaves at least two data edges for the largest latency in use.
module hbw_seg_plan #(
    parameter int MAX_CSL = 800,
    parameter int LW      = 16,
    parameter int CW      = 10
) (
    input  logic          odd_start,
    input  logic [LW-1:0] remain,
    input  logic [CW-1:0] lat_edges,
    output logic [LW-1:0] seg_bytes,
    output logic [CW-1:0] seg_edges
);
    import hbw_pkg::*;

    // Budget arithmetic on plain integers.
    always_comb begin
        int avail, cap, k, e;
        avail = MAX_CSL - CS_OVERHEAD - int'(lat_edges);
        avail = avail - (avail % 2);
        cap   = avail - int'(odd_start);
        k     = (int'(remain) < cap) ? int'(remain) : cap;
        e     = k + int'(odd_start);
        e     = e + (e % 2);
        seg_bytes = LW'(k);
        seg_edges = CW'(e);
    end
endmodule

// File: rtl/hb_write_seq.sv
// HyperBus write transaction sequencer.
// Runs one write request as one or more bus transactions (select, command/address,
// single or double latency, data, deselect), splitting so chip select stays low at
// most MAX_CSL core cycles. One bus clock edge per core cycle while the clock runs.
// Assumes lat_clocks stays in 3..12 and constant while a request is in progress,
// and that MAX_CSL fits the largest latency plus two data edges.
module hb_write_seq
    import hbw_pkg::*;
#(
    parameter int AW      = 32,
    parameter int LW      = 16,
    parameter int MAX_CSL = 800,
    parameter int CSH_MIN = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic [LW-1:0] req_len,
    output logic          req_ready,
    input  logic [3:0]    lat_clocks,
    input  logic [7:0]    wr_data,
    input  logic          wr_be,
    output logic          wr_ready,
    output logic          done,
    output logic          hb_cs_n,
    output logic          hb_ck,
    output logic [7:0]    hb_dq_o,
    output logic          hb_dq_oe,
    input  logic          hb_rwds_i,
    output logic          hb_rwds_o,
    output logic          hb_rwds_oe
);
    localparam int CW = $clog2(MAX_CSL + 1);

    seq_state_e    st;
    logic [CW-1:0] cnt, lat_total, edges_left, csl_cnt, hi_cnt;
    logic [AW-1:0] seg_addr, seg_end, pos;
    logic [LW-1:0] remain, seg_k, plan_k;
    logic [CW-1:0] plan_e, lat_now;
    logic [47:0]   ca_q;
    logic [7:0]    ca_b, edge_dq;
    logic [2:0]    ca_idx;
    logic          ck_q, cs_n_q, dq_oe_q, rwds_o_q, rwds_oe_q, done_q;
    logic [7:0]    dq_q;
    logic          pos_ok, data_edge, edge_mask;

    // Latency edge count chosen by the RWDS level seen now.
    assign lat_now = hb_rwds_i ? CW'({lat_clocks, 2'b00}) : CW'({lat_clocks, 1'b0});
    assign ca_idx  = (st == ST_SEL) ? 3'd0 : cnt[2:0];

    hbw_ca_byte u_ca (.ca(ca_q), .idx(ca_idx), .byte_o(ca_b));

    hbw_seg_plan #(.MAX_CSL(MAX_CSL), .LW(LW), .CW(CW)) u_plan (
        .odd_start(seg_addr[0]), .remain(remain), .lat_edges(lat_now),
        .seg_bytes(plan_k), .seg_edges(plan_e)
    );

    // Decides whether the edge emitted at the next clock carries a requested byte.
    always_comb begin
        data_edge = ((st == ST_LAT) && (cnt == lat_total)) ||
                    ((st == ST_DATA) && (edges_left != '0));
        pos_ok    = (pos >= seg_addr) && (pos < seg_end);
        edge_dq   = pos_ok ? wr_data : 8'h00;
        edge_mask = pos_ok ? ~wr_be : 1'b1;
    end

    assign wr_ready   = data_edge && pos_ok;
    assign req_ready  = (st == ST_IDLE);
    assign done       = done_q;
    assign hb_cs_n    = cs_n_q;
    assign hb_ck      = ck_q;
    assign hb_dq_o    = dq_q;
    assign hb_dq_oe   = dq_oe_q;
    assign hb_rwds_o  = rwds_o_q;
    assign hb_rwds_oe = rwds_oe_q;

    // Phase sequencer; every output is registered here.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE; cnt <= '0; lat_total <= '0; edges_left <= '0;
            seg_addr <= '0; seg_end <= '0; pos <= '0; remain <= '0; seg_k <= '0;
            ca_q <= '0; ck_q <= 1'b0; cs_n_q <= 1'b1; dq_q <= '0; dq_oe_q <= 1'b0;
            rwds_o_q <= 1'b0; rwds_oe_q <= 1'b0; done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st)
                ST_IDLE: if (req_valid && (req_len != '0)) begin
                    seg_addr <= req_addr;
                    remain   <= req_len;
                    ca_q     <= build_ca(32'(req_addr >> 1));
                    cs_n_q   <= 1'b0;
                    dq_oe_q  <= 1'b1;
                    st       <= ST_SEL;
                end
                ST_SEL: begin
                    ck_q <= 1'b1; dq_q <= ca_b; cnt <= CW'(1); st <= ST_CA;
                end
                ST_CA: if (cnt != CW'(CA_BYTES)) begin
                    ck_q <= ~ck_q; dq_q <= ca_b; cnt <= cnt + CW'(1);
                end else begin
                    lat_total  <= lat_now;
                    seg_k      <= plan_k;
                    seg_end    <= seg_addr + AW'(plan_k);
                    edges_left <= plan_e;
                    pos        <= {seg_addr[AW-1:1], 1'b0};
                    ck_q <= 1'b1; dq_q <= 8'h00; cnt <= CW'(1); st <= ST_LAT;
                end
                ST_LAT: if (cnt != lat_total) begin
                    ck_q      <= ~ck_q;
                    cnt       <= cnt + CW'(1);
                    rwds_oe_q <= (cnt >= lat_total - CW'(2));
                    rwds_o_q  <= 1'b0;
                end else begin
                    ck_q <= 1'b1; dq_q <= edge_dq; rwds_o_q <= edge_mask; rwds_oe_q <= 1'b1;
                    edges_left <= edges_left - CW'(1); pos <= pos + AW'(1); st <= ST_DATA;
                end
                ST_DATA: if (edges_left != '0) begin
                    ck_q <= ~ck_q; dq_q <= edge_dq; rwds_o_q <= edge_mask;
                    edges_left <= edges_left - CW'(1); pos <= pos + AW'(1);
                end else begin
                    cs_n_q <= 1'b1; dq_oe_q <= 1'b0; rwds_oe_q <= 1'b0; rwds_o_q <= 1'b0;
                    dq_q <= 8'h00; seg_addr <= seg_end; remain <= remain - seg_k;
                    cnt <= CW'(1); st <= ST_GAP;
                end
                ST_GAP: if (cnt < CW'(CSH_MIN)) begin
                    cnt <= cnt + CW'(1);
                end else if (remain != '0) begin
                    ca_q <= build_ca(32'(seg_addr >> 1)); cs_n_q <= 1'b0; dq_oe_q <= 1'b1; st <= ST_SEL;
                end else begin
                    done_q <= 1'b1; st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Run-length counters of chip-select low and high, kept for the checks below.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csl_cnt <= '0; hi_cnt <= CW'(CSH_MIN);
        end else begin
            csl_cnt <= cs_n_q ? '0 : csl_cnt + CW'(1);
            hi_cnt  <= !cs_n_q ? '0 : ((hi_cnt != '1) ? hi_cnt + CW'(1) : hi_cnt);
        end
    end

    AST_CK_LOW_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n) cs_n_q |-> !ck_q); // R6
    AST_CS_RISE_CK_LOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(cs_n_q) |-> !$past(ck_q)); // R6
    AST_CSL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) !cs_n_q |-> (csl_cnt < CW'(MAX_CSL))); // R7
    AST_GAP_MIN: assert property (@(posedge clk) disable iff (!rst_n) $fell(cs_n_q) |-> (hi_cnt >= CW'(CSH_MIN))); // R8
    AST_NO_DRIVE_CA: assert property (@(posedge clk) disable iff (!rst_n) (st == ST_CA) |-> !rwds_oe_q); // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done_q |=> !done_q); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> (cs_n_q && !rwds_oe_q)); // R1
endmodule

// File: tb/sim_hb_write_seq.sv
module sim_hb_write_seq;
    localparam int AW = 32, LW = 16, MAXC = 72, CSH = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_ready, wr_be = 1'b0, wr_ready, done;
    logic [AW-1:0] req_addr = '0;
    logic [LW-1:0] req_len = '0;
    logic [3:0] lat_clocks = 4'd3;
    logic [7:0] wr_data = 8'h00, hb_dq_o;
    logic hb_cs_n, hb_ck, hb_dq_oe, hb_rwds_i, hb_rwds_o, hb_rwds_oe;

    int checks = 0, fails = 0;
    bit finished = 1'b0;

    logic [7:0] mem [256];
    logic [7:0] emem [256];
    logic [7:0] dat [256];
    logic       be_a [256];
    int idx = 0; bit took = 1'b0;
    int lat_cfg = 3; bit cur_dbl = 1'b0, alt_mode = 1'b0;
    int exp_q [$];
    int seg_cnt = 0, edge_i = 0, lat_e = 0, low_len = 0, hi_len = 100;
    logic [47:0] ca_sh = '0; logic [31:0] wa_seen = '0;
    logic prev_ck = 1'b0, prev_cs = 1'b1;

    always #2.5 clk = ~clk;

    assign hb_rwds_i = !hb_cs_n && cur_dbl;

    hb_write_seq #(.AW(AW), .LW(LW), .MAX_CSL(MAXC), .CSH_MIN(CSH)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_len(req_len), .req_ready(req_ready), .lat_clocks(lat_clocks),
        .wr_data(wr_data), .wr_be(wr_be), .wr_ready(wr_ready), .done(done),
        .hb_cs_n(hb_cs_n), .hb_ck(hb_ck), .hb_dq_o(hb_dq_o), .hb_dq_oe(hb_dq_oe),
        .hb_rwds_i(hb_rwds_i), .hb_rwds_o(hb_rwds_o), .hb_rwds_oe(hb_rwds_oe)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    // Data stream source: advances after each consumed byte.
    always @(negedge clk) begin
        if (took) idx++;
        wr_data = dat[idx[7:0]];
        wr_be   = be_a[idx[7:0]];
        took    = wr_ready;
    end

    // Memory model and bus-rule observer, evaluated every cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(!(hb_cs_n && hb_ck), "R6 clock high while deselected", hb_ck, 0);
            if (hb_cs_n != prev_cs)
                chk(!hb_ck && !prev_ck, "R6 select changed with clock high", hb_ck | prev_ck, 0);
            if (!hb_cs_n && prev_cs) begin
                seg_cnt++;
                chk(hi_len >= CSH, "R8 deselect gap", hi_len, CSH);
                edge_i = 0; low_len = 0;
                lat_e = (cur_dbl ? 4 : 2) * lat_cfg;
            end
            if (!hb_cs_n) low_len++;
            if (!hb_cs_n && (hb_ck != prev_ck)) begin
                if (edge_i < 6) begin
                    ca_sh = {ca_sh[39:0], hb_dq_o};
                    chk(!hb_rwds_oe, "R4 RWDS driven during command/address", hb_rwds_oe, 0);
                    if (edge_i == 5) begin
                        int e;
                        e = (exp_q.size() != 0) ? exp_q.pop_front() : -2;
                        wa_seen = {ca_sh[44:16], ca_sh[2:0]};
                        chk(ca_sh[47:45] == 3'b001, "R2 command bits", ca_sh[47:45], 1);
                        chk(ca_sh[15:3] == 13'd0, "R2 reserved bits", ca_sh[15:3], 0);
                        chk(int'(wa_seen) == e / 2, "R2 R7 segment word address", wa_seen, e / 2);
                    end
                end else if (edge_i < 6 + lat_e) begin
                    bit pre;
                    pre = (edge_i >= 6 + lat_e - 2);
                    chk((hb_rwds_oe == pre) && !(pre && hb_rwds_o), "R3 R4 latency RWDS preamble",
                        {hb_rwds_oe, hb_rwds_o}, pre ? 2 : 0);
                end else begin
                    int a;
                    a = int'(wa_seen) * 2 + (edge_i - 6 - lat_e);
                    chk(hb_rwds_oe && hb_dq_oe, "R5 mask or data not driven", hb_rwds_oe, 1);
                    if (!hb_rwds_o) mem[a[7:0]] = hb_dq_o;
                end
                edge_i++;
            end
            if (hb_cs_n && !prev_cs) begin
                int d;
                d = edge_i - 6 - lat_e;
                chk(low_len <= MAXC, "R7 select low time", low_len, MAXC);
                chk((d >= 2) && (d % 2 == 0), "R5 R10 data edge count", d, 2);
                hi_len = 0;
                if (alt_mode) cur_dbl = !cur_dbl;
            end
            if (hb_cs_n) hi_len++;
        end
        prev_ck = hb_ck; prev_cs = hb_cs_n;
    end

    task automatic run_xfer(input int addr, input int len, input int lat, input bit dbl,
                            input bit alt, input int bemode, input bit poke_busy);
        int p, r, nseg, mm; bit d, got;
        for (int i = 0; i < 256; i++) emem[i] = mem[i];
        for (int i = 0; i < len; i++) begin
            dat[i]  = 8'(((i * 29) + (addr * 7) + len) ^ 8'h5A);
            be_a[i] = (bemode == 0) ? 1'b1 : (bemode == 1) ? 1'(i % 2) : (i % 3 != 1);
            if (be_a[i]) emem[addr + i] = dat[i];
        end
        p = addr; r = len; d = dbl; nseg = 0;
        while (r > 0) begin
            int le, em, cap, k;
            le = (d ? 4 : 2) * lat;
            em = MAXC - 8 - le; em = em - (em % 2);
            cap = em - (p % 2);
            k = (r < cap) ? r : cap;
            exp_q.push_back(p);
            p += k; r -= k; nseg++;
            if (alt) d = !d;
        end
        lat_cfg = lat; lat_clocks = 4'(lat); cur_dbl = dbl; alt_mode = alt;
        idx = 0; took = 1'b0; seg_cnt = 0;
        chk(req_ready, "R9 ready while idle", req_ready, 1);
        req_addr = AW'(addr); req_len = LW'(len); req_valid = 1'b1;
        tick();
        req_valid = 1'b0;
        got = 1'b0;
        for (int w = 0; w < 20000; w++) begin
            if (poke_busy && w == 5) begin
                req_addr = AW'(240); req_len = LW'(5); req_valid = 1'b1;
                chk(!req_ready, "R9 ready low while busy", req_ready, 0);
            end
            if (poke_busy && w == 8) req_valid = 1'b0;
            if (done) begin got = 1'b1; break; end
            tick();
        end
        chk(got, "R9 done pulse seen", got, 1);
        chk(hb_cs_n, "R9 select high at done", hb_cs_n, 1);
        tick();
        chk(!done, "R9 done lasts one cycle", done, 0);
        mm = 0;
        for (int i = 0; i < 256; i++) if (mem[i] !== emem[i]) mm++;
        chk(mm == 0, "R5 memory holds exactly the enabled bytes", mm, 0);
        chk(seg_cnt == nseg, "R10 R7 transaction count", seg_cnt, nseg);
        chk(idx == len, "R5 stream bytes consumed", idx, len);
        chk(exp_q.size() == 0, "R2 all planned segments seen", exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) begin mem[i] = 8'hEE; dat[i] = 8'h00; be_a[i] = 1'b0; end
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk(hb_cs_n && !hb_ck, "R1 bus idle after reset", {hb_cs_n, hb_ck}, 2);
        chk(!hb_dq_oe && !hb_rwds_oe, "R1 outputs not driven", {hb_dq_oe, hb_rwds_oe}, 0);
        chk(req_ready && !done, "R1 ready and no done", {req_ready, done}, 2);
        // R9 zero-length request ignored
        req_addr = AW'(5); req_len = '0; req_valid = 1'b1;
        for (int i = 0; i < 4; i++) begin
            tick();
            chk(hb_cs_n && req_ready && !done, "R9 zero length ignored", {hb_cs_n, req_ready, done}, 6);
        end
        req_valid = 1'b0;
        tick();
        run_xfer(10, 8, 3, 1'b0, 1'b0, 0, 1'b1);   // R5 aligned, busy requests ignored (R9)
        run_xfer(21, 6, 4, 1'b0, 1'b0, 0, 1'b0);   // R5 odd start and odd end padding
        run_xfer(40, 12, 5, 1'b1, 1'b0, 1, 1'b0);  // R3 double latency, R5 alternate enables
        run_xfer(65, 100, 3, 1'b0, 1'b0, 2, 1'b0); // R7 R10 split from odd start
        run_xfer(130, 40, 6, 1'b1, 1'b1, 0, 1'b0); // R3 R10 latency changes between pieces
        run_xfer(180, 50, 12, 1'b0, 1'b0, 2, 1'b0);// R3 longest latency with split
        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule